// File: doc/BRIEF.md
# Processor Exception Priority Sequencer

This block sits beside a processor core and decides the order in which exception processing is carried out. The core raises one request line per exception class. Each request is latched as pending. At every decision point the block picks the most urgent eligible class and runs a short processing sequence for it. The sequence is a fixed number of steps, and each step is acknowledged by `step_done`. The sequence ends with a context-frame push, offered on a valid/ready output that carries the class's vector number and a frame-type code.

Classes are processed from most urgent to least urgent. Each one pushes its own frame, so the handler that runs first is the one for the last frame pushed. When nothing is left pending after a chain of pushes, the block pulses `hand_valid` for one cycle with that vector. Address and bus errors may interrupt a sequence that is already running; the interrupted sequence is parked on a small internal stack and later resumes at the step it had reached. A reset-class request abandons everything and pushes a "no frame" marker. Interrupt-like classes start only at an instruction boundary.

The push port follows valid/ready rules. Once `push_valid` is high it stays high, with `push_vector` and `push_kind` unchanged, until a cycle in which `push_ready` is high; the frame is taken in that cycle. The only exception is a reset-class abort. While `push_ready` is low, no other frame is offered and no processing step advances. All other pins are plain control and status.

Top module: `exc_prio_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `push_valid`, `hand_valid` and `run_active` are all 0.
- R2: Each `exc_req` bit is held pending until its sequence starts. Index 0 is the most urgent and index 7 the least urgent. Requests that are pending together are processed and pushed in ascending index order. The vectors are: index 0→0, 1→3, 2→2, 3→32, 4→4, 5→9, 6→12, 7→24.
- R3: `push_kind` is 0 (no frame) for index 0, 1 (suspend frame) for indexes 1 and 2, and 2 (normal frame) for indexes 3 to 7.
- R4: A sequence takes exactly STEPS cycles with `step_done` high while `run_active` is high. `run_step` counts these from 0. `push_valid` rises in the cycle after the last one.
- R5: Indexes 5, 6 and 7 start only in a decision cycle where `instr_done` is high, or while a chain of pushes is still unfinished. Until then they stay pending and `run_active` stays 0.
- R6: A pending index 1 or 2 pre-empts a running sequence of larger index. The pre-empted class and step are saved on a stack SUSP_DEPTH deep. That sequence later resumes at the saved step. The new sequence starts at step 0. A `step_done` in the pre-empting cycle is not counted.
- R7: While `push_valid` is high and `push_ready` is low, the push holds its vector and kind into the next cycle, unless a reset-class request is pending.
- R8: When a chain of pushes ends and nothing is pending, `hand_valid` is high for exactly one cycle. `hand_vector` is the vector of the last frame pushed. `push_valid` and `run_active` are low during that cycle.
- R9: A pending index 0 aborts any running sequence or push. It clears all other pending requests and the suspend stack, and then pushes vector 0 with kind 0. The following handler pulse carries vector 0.
- R10: `run_group` reports how the running class relates to the instruction stream: 0 aborts, 1 suspends, 2 is part of the instruction, 3 comes before the instruction, and 4 waits for the instruction boundary. Index 0 maps to 0, indexes 1 and 2 to 1, index 3 to 2, index 4 to 3, and indexes 5 to 7 to 4.
- R11: A request of index 3 or higher that arrives while a sequence runs does not interrupt it. It is taken at the next decision point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 8 | One request line per exception class, index 0 most urgent |
| instr_done | input | 1 | The core is at an instruction boundary |
| step_done | input | 1 | Acknowledge of the current processing step |
| push_valid | output | 1 | A context frame is offered |
| push_ready | input | 1 | The frame is accepted in this cycle |
| push_vector | output | 8 | Vector number of the frame |
| push_kind | output | 2 | Frame type: 0 none, 1 suspend, 2 normal |
| run_active | output | 1 | A processing sequence is running |
| run_class | output | 3 | Index of the running class |
| run_group | output | 3 | Behaviour group of the running class (see R10) |
| run_step | output | STEP_W | Current step of the running sequence |
| hand_valid | output | 1 | One-cycle pulse: start the first handler |
| hand_vector | output | 8 | Vector of the handler to run first |

## Verification
The assertions assume that requests are cycle pulses from the core and that `push_ready` may drop at any time. They also assume that `instr_done` is a level that the block samples only at decision points. Nothing is assumed about `step_done` outside a running sequence.

The random scenarios hold `instr_done` high, so that every interrupt-class request eventually starts. They leave a scenario only after the handler pulse has been seen, so the previous chain never bleeds into the next one. The directed cases that test pre-emption, the boundary wait and the abort drive `step_done` by hand, so that each request lands while a known sequence is at a known step.

// File: rtl/epq_pkg.sv
package epq_pkg;
  localparam int NCLS  = 8;
  localparam int CLS_W = $clog2(NCLS);
  localparam int VEC_W = 8;

  localparam logic [NCLS-1:0] RST_MASK = 8'b0000_0001;
  localparam logic [NCLS-1:0] G1_MASK  = 8'b0000_0110;
  localparam logic [NCLS-1:0] G4_MASK  = 8'b1110_0000;

  localparam logic [1:0] FR_NONE = 2'd0;
  localparam logic [1:0] FR_SUSP = 2'd1;
  localparam logic [1:0] FR_NORM = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PUSH, ST_HAND} seq_st_e;

  function automatic logic [VEC_W-1:0] cls_vector(input logic [CLS_W-1:0] c);
    case (c)
      3'd0:    return 8'd0;
      3'd1:    return 8'd3;
      3'd2:    return 8'd2;
      3'd3:    return 8'd32;
      3'd4:    return 8'd4;
      3'd5:    return 8'd9;
      3'd6:    return 8'd12;
      default: return 8'd24;
    endcase
  endfunction

  function automatic logic [1:0] cls_frame(input logic [CLS_W-1:0] c);
    if (c == 3'd0)                    return FR_NONE;
    else if (c == 3'd1 || c == 3'd2)  return FR_SUSP;
    else                              return FR_NORM;
  endfunction

  function automatic logic [2:0] cls_group(input logic [CLS_W-1:0] c);
    case (c)
      3'd0:       return 3'd0;
      3'd1, 3'd2: return 3'd1;
      3'd3:       return 3'd2;
      3'd4:       return 3'd3;
      default:    return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/epq_pending.sv
module epq_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] take,
  input  logic         clr_all,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)       pend[i] <= 1'b0;
      else if (clr_all) pend[i] <= 1'b0;
      else              pend[i] <= (pend[i] & ~take[i]) | req[i];
    end
  end
endmodule

// File: rtl/epq_pick.sv
module epq_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
  assign valid = |mask;
endmodule

// File: rtl/epq_susp_stack.sv
module epq_susp_stack #(
  parameter int W     = 5,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]     slot [DEPTH];
  logic [CNT_W-1:0] cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                            slot[i] <= '0;
      else if (push && cnt == CNT_W'(i))     slot[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (flush)         cnt <= '0;
    else if (push && !full) cnt <= cnt + 1'b1;
    else if (pop && !empty) cnt <= cnt - 1'b1;
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) dout = slot[i];
    end
  end

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/exc_prio_seq.sv
module exc_prio_seq
  import epq_pkg::*;
#(
  parameter int STEPS      = 4,
  parameter int SUSP_DEPTH = 2,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   exc_req,
  input  logic              instr_done,
  input  logic              step_done,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [VEC_W-1:0]  push_vector,
  output logic [1:0]        push_kind,
  output logic              run_active,
  output logic [CLS_W-1:0]  run_class,
  output logic [2:0]        run_group,
  output logic [STEP_W-1:0] run_step,
  output logic              hand_valid,
  output logic [VEC_W-1:0]  hand_vector
);
  localparam int ENT_W = CLS_W + STEP_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  seq_st_e            st_q;
  logic [CLS_W-1:0]   cur_cls_q;
  logic [STEP_W-1:0]  cur_step_q;
  logic               chain_q;
  logic [VEC_W-1:0]   last_vec_q;

  logic [NCLS-1:0]    pend_q, elig, take;
  logic               clr_all, abort, boundary;
  logic               pk_v, g1_v, preempt;
  logic [CLS_W-1:0]   pk_idx, g1_idx;
  logic               s_push, s_pop;
  logic [ENT_W-1:0]   stk_top;
  logic               stk_full, stk_empty;

  epq_pending #(.N(NCLS)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(exc_req), .take(take),
    .clr_all(clr_all), .pend(pend_q)
  );

  // Classes that wait for a boundary become eligible at one, or inside a chain
  assign boundary = instr_done | chain_q;
  assign elig = (pend_q & ~G4_MASK & ~RST_MASK) |
                (boundary ? (pend_q & G4_MASK) : '0);

  epq_pick #(.N(NCLS)) u_pick_main (
    .mask(elig), .valid(pk_v), .idx(pk_idx)
  );

  epq_pick #(.N(NCLS)) u_pick_g1 (
    .mask(pend_q & G1_MASK), .valid(g1_v), .idx(g1_idx)
  );

  epq_susp_stack #(.W(ENT_W), .DEPTH(SUSP_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(s_push), .pop(s_pop), .flush(abort),
    .din({cur_cls_q, cur_step_q}), .dout(stk_top),
    .full(stk_full), .empty(stk_empty)
  );

  assign abort   = pend_q[0];
  assign preempt = (st_q == ST_RUN) && g1_v && (g1_idx < cur_cls_q) &&
                   !stk_full && !abort;

  always_comb begin
    take    = '0;
    clr_all = 1'b0;
    s_push  = 1'b0;
    s_pop   = 1'b0;
    if (abort) begin
      clr_all = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (pk_v) take = NCLS'(1) << pk_idx;
        ST_RUN: if (preempt) begin
          s_push = 1'b1;
          take   = NCLS'(1) << g1_idx;
        end
        ST_PUSH: if (push_ready && !stk_empty) s_pop = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_cls_q  <= '0;
      cur_step_q <= '0;
      chain_q    <= 1'b0;
      last_vec_q <= '0;
    end else if (abort) begin
      st_q       <= ST_PUSH;
      cur_cls_q  <= '0;
      cur_step_q <= '0;
      chain_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (pk_v) begin
            st_q       <= ST_RUN;
            cur_cls_q  <= pk_idx;
            cur_step_q <= '0;
          end else if (chain_q) begin
            st_q <= ST_HAND;
          end
        end
        ST_RUN: begin
          if (preempt) begin
            cur_cls_q  <= g1_idx;
            cur_step_q <= '0;
          end else if (step_done) begin
            if (cur_step_q == LAST_STEP) st_q <= ST_PUSH;
            else                         cur_step_q <= cur_step_q + 1'b1;
          end
        end
        ST_PUSH: begin
          if (push_ready) begin
            last_vec_q <= cls_vector(cur_cls_q);
            chain_q    <= 1'b1;
            if (!stk_empty) begin
              st_q                    <= ST_RUN;
              {cur_cls_q, cur_step_q} <= stk_top;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: begin
          chain_q <= 1'b0;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign push_valid  = (st_q == ST_PUSH);
  assign push_vector = cls_vector(cur_cls_q);
  assign push_kind   = cls_frame(cur_cls_q);
  assign run_active  = (st_q == ST_RUN);
  assign run_class   = cur_cls_q;
  assign run_group   = cls_group(cur_cls_q);
  assign run_step    = cur_step_q;
  assign hand_valid  = (st_q == ST_HAND);
  assign hand_vector = last_vec_q;
endmodule

// File: rtl/epq_checker.sv
module epq_checker #(
  parameter int STEPS  = 4,
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        exc_req,
  input logic              instr_done,
  input logic              step_done,
  input logic              push_valid,
  input logic              push_ready,
  input logic [7:0]        push_vector,
  input logic [1:0]        push_kind,
  input logic              run_active,
  input logic [2:0]        run_class,
  input logic [STEP_W-1:0] run_step,
  input logic              hand_valid,
  input logic [7:0]        pend,
  input logic              chain
);
  assert_push_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready && !pend[0]
    |=> push_valid && $stable(push_vector) && $stable(push_kind));

  assert_hand_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hand_valid |=> !hand_valid);

  assert_hand_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hand_valid |-> !push_valid && !run_active);

  assert_boundary_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_active && !$past(run_active) && run_class >= 3'd5
    |-> $past(instr_done) || $past(chain) || $past(push_valid));

  assert_preempt_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_active && $past(run_active) && run_class != $past(run_class)
    |-> run_class < $past(run_class) && (run_class == 3'd1 || run_class == 3'd2)
        && run_step == '0);

  assert_step_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !$past(push_valid) && push_kind != 2'd0
    |-> $past(run_active) && $past(step_done) &&
        $past(run_step) == STEP_W'(STEPS - 1));

  assert_abort_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |=> push_valid && push_kind == 2'd0 && !run_active);

  assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |=> pend == $past(exc_req));
endmodule

bind exc_prio_seq epq_checker #(.STEPS(STEPS), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .instr_done(instr_done),
  .step_done(step_done), .push_valid(push_valid), .push_ready(push_ready),
  .push_vector(push_vector), .push_kind(push_kind), .run_active(run_active),
  .run_class(run_class), .run_step(run_step), .hand_valid(hand_valid),
  .pend(pend_q), .chain(chain_q)
);

// File: tb/exc_prio_seq_test.sv
`timescale 1ns/100ps
module exc_prio_seq_test;
  localparam int STEPS = 4;
  localparam int SW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    exc_req = '0;
  logic          instr_done = 1'b1;
  logic          step_done = 1'b0;
  logic          push_ready = 1'b1;
  logic          push_valid, run_active, hand_valid;
  logic [7:0]    push_vector, hand_vector;
  logic [1:0]    push_kind;
  logic [2:0]    run_class, run_group;
  logic [SW-1:0] run_step;

  always #2 clk = ~clk;

  exc_prio_seq #(.STEPS(STEPS), .SUSP_DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .instr_done(instr_done),
    .step_done(step_done), .push_valid(push_valid), .push_ready(push_ready),
    .push_vector(push_vector), .push_kind(push_kind), .run_active(run_active),
    .run_class(run_class), .run_group(run_group), .run_step(run_step),
    .hand_valid(hand_valid), .hand_vector(hand_vector)
  );

  int n_chk = 0, n_bad = 0, grp_bad = 0;
  int np = 0, nh = 0;
  logic [7:0] lv [256];
  logic [1:0] lk [256];
  logic [7:0] last_h = '0;
  bit auto_step = 1'b1, auto_ready = 1'b1;

  function automatic int exp_vec(input int c);
    case (c)
      0: return 0;  1: return 3;  2: return 2;  3: return 32;
      4: return 4;  5: return 9;  6: return 12; default: return 24;
    endcase
  endfunction

  function automatic int exp_kind(input int c);
    if (c == 0) return 0;
    if (c <= 2) return 1;
    return 2;
  endfunction

  function automatic int exp_grp(input int c);
    if (c == 0) return 0;
    if (c <= 2) return 1;
    if (c == 3) return 2;
    if (c == 4) return 3;
    return 4;
  endfunction

  // random handshake drivers, active only when enabled
  always @(negedge clk) begin
    if (auto_step)  step_done  = ($urandom % 2) == 0;
    if (auto_ready) push_ready = ($urandom % 5) != 0;
  end

  // monitor just before each rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (push_valid && push_ready && np < 256) begin
        lv[np] = push_vector;
        lk[np] = push_kind;
        np++;
      end
      if (hand_valid) begin
        nh++;
        last_h = hand_vector;
      end
      if (run_active && int'(run_group) != exp_grp(int'(run_class))) grp_bad++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1.5;
  endtask

  task automatic pulse_req(input logic [7:0] m);
    @(negedge clk);
    exc_req = m;
    @(negedge clk);
    exc_req = '0;
    #1.5;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    step_done = 1'b1;
    @(negedge clk);
    step_done = 1'b0;
    #1.5;
  endtask

  task automatic wait_hand();
    int n0 = nh;
    for (int i = 0; i < 3000 && nh == n0; i++) settle();
  endtask

  task automatic wait_run(input int c);
    for (int i = 0; i < 20 && !(run_active && int'(run_class) == c); i++) settle();
  endtask

  task automatic chk_push(input int idx, input int c, input string tag);
    check(idx < np && int'(lv[idx]) == exp_vec(c), tag, int'(lv[idx]), exp_vec(c));
    check(idx < np && int'(lk[idx]) == exp_kind(c), tag, int'(lk[idx]), exp_kind(c));
  endtask

  initial begin
    #600us;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] m;
    int hi;
    bit ok;
    logic [7:0] v0;
    void'($urandom(32'h5eed));

    // R1: reset state
    repeat (3) settle();
    check(!push_valid && !hand_valid && !run_active, "R1", int'(push_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1.5;
    check(!push_valid && !hand_valid && !run_active, "R1", int'(run_active), 0);

    // R5: boundary-waiting class holds until instr_done
    auto_step = 1'b1;
    instr_done = 1'b0;
    base = np;
    pulse_req(8'h80);
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      settle();
      if (run_active || push_valid) ok = 1'b0;
    end
    check(ok, "R5", int'(run_active), 0);
    @(negedge clk);
    instr_done = 1'b1;
    wait_hand();
    check(np == base + 1, "R5", np - base, 1);
    chk_push(base, 7, "R5");
    check(int'(last_h) == 24, "R8", int'(last_h), 24);

    // R7: back-pressure on the push port
    auto_ready = 1'b0;
    push_ready = 1'b0;
    base = np;
    pulse_req(8'h08);
    for (int i = 0; i < 40 && !push_valid; i++) settle();
    v0 = push_vector;
    ok = push_valid;
    for (int i = 0; i < 5; i++) begin
      settle();
      if (!push_valid || push_vector != v0 || push_kind != 2'd2) ok = 1'b0;
    end
    check(ok && v0 == 8'd32, "R7", int'(v0), 32);
    auto_ready = 1'b1;
    wait_hand();
    check(np == base + 1, "R7", np - base, 1);
    chk_push(base, 3, "R3");

    // R4 and R11: exact step count, later arrival waits
    auto_step = 1'b0;
    step_done = 1'b0;
    base = np;
    pulse_req(8'h10);
    wait_run(4);
    check(int'(run_group) == 3, "R10", int'(run_group), 3);
    pulse_req(8'h08);
    for (int i = 0; i < 3; i++) pulse_step();
    check(!push_valid && int'(run_step) == 3, "R4", int'(run_step), 3);
    check(run_active && int'(run_class) == 4, "R11", int'(run_class), 4);
    pulse_step();
    check(push_valid == 1'b1, "R4", int'(push_valid), 1);
    auto_step = 1'b1;
    wait_hand();
    check(np == base + 2, "R11", np - base, 2);
    chk_push(base, 4, "R11");
    chk_push(base + 1, 3, "R11");
    check(int'(last_h) == 32, "R8", int'(last_h), 32);

    // R6: nested suspension with resume at the saved step
    auto_step = 1'b0;
    step_done = 1'b0;
    base = np;
    pulse_req(8'h20);
    wait_run(5);
    check(int'(run_group) == 4, "R10", int'(run_group), 4);
    pulse_step();
    check(int'(run_step) == 1, "R4", int'(run_step), 1);
    pulse_req(8'h04);
    wait_run(2);
    check(int'(run_step) == 0 && int'(run_group) == 1, "R6", int'(run_step), 0);
    pulse_step();
    pulse_req(8'h02);
    wait_run(1);
    check(run_active && int'(run_class) == 1, "R6", int'(run_class), 1);
    for (int i = 0; i < 4; i++) pulse_step();
    wait_run(2);
    check(run_active && int'(run_step) == 1, "R6", int'(run_step), 1);
    for (int i = 0; i < 3; i++) pulse_step();
    wait_run(5);
    check(run_active && int'(run_step) == 1, "R6", int'(run_step), 1);
    auto_step = 1'b1;
    wait_hand();
    check(np == base + 3, "R6", np - base, 3);
    chk_push(base, 1, "R6");
    chk_push(base + 1, 2, "R6");
    chk_push(base + 2, 5, "R6");
    check(int'(last_h) == 9, "R8", int'(last_h), 9);

    // R9: reset-class abort
    auto_step = 1'b0;
    step_done = 1'b0;
    base = np;
    pulse_req(8'hC0);
    wait_run(6);
    check(run_active && int'(run_class) == 6, "R2", int'(run_class), 6);
    pulse_req(8'h01);
    auto_step = 1'b1;
    wait_hand();
    for (int i = 0; i < 30; i++) settle();
    check(np == base + 1, "R9", np - base, 1);
    chk_push(base, 0, "R9");
    check(int'(last_h) == 0, "R9", int'(last_h), 0);

    // R2, R3, R8: random simultaneous request sets
    instr_done = 1'b1;
    for (int k = 0; k < 40; k++) begin
      m = 8'($urandom) & 8'hFE;
      if (m == 8'h00) m = 8'h20;
      base = np;
      pulse_req(m);
      wait_hand();
      ok = 1'b1;
      hi = 0;
      for (int c = 1; c < 8; c++) begin
        if (m[c]) begin
          if (base >= np || int'(lv[base]) != exp_vec(c) || int'(lk[base]) != exp_kind(c))
            ok = 1'b0;
          base++;
          hi = c;
        end
      end
      check(ok && base == np, "R2", np, base);
      check(int'(last_h) == exp_vec(hi), "R8", int'(last_h), exp_vec(hi));
      for (int i = 0; i < 3; i++) settle();
    end

    check(grp_bad == 0, "R10", grp_bad, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule